// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands (1 sign bit, 8-bit biased exponent, 23-bit fraction) and returns the packed product one clock after the operands are presented. The block splits each operand into its fields and XORs the two signs. It adds the biased exponents and removes the bias once, then multiplies the two 24-bit significands with their hidden ones restored. The full product lies in [1,4), so a single one-bit right shift is enough to normalize it. The kept fraction is then rounded to nearest-even, or truncated when the mode input asks for it, and the result is repacked.

Operands with a zero exponent field count as zero, so subnormals are flushed. Zeros, infinities and NaNs follow fixed special-operand rules. Results that fall outside the normal exponent range become signed infinity or signed zero, and a status flag marks the case. The widths are parameters, but the requirements below use the default 8/23 split.

Top module: `fp_mul32`

## Requirements
- R1: Outputs are registered: the result and flags for operands present at a rising clock edge appear after that edge, and an active-low reset clears the result and all three flags to zero.
- R2: The result sign (bit 31) is the XOR of the operand signs for every result except the invalid NaN, including zero and infinity results.
- R3: For two normal operands the result exponent is ea+eb-127. The result significand is the product of the two 1.f significands. When that product is 2 or more it is shifted right by one bit and the exponent rises by one.
- R4: When trunc_mode is 0 the 23-bit fraction is rounded to nearest with ties to even. The guard bit is the first dropped product bit, and sticky is the OR of all bits below it. When trunc_mode is 1 the dropped bits are discarded.
- R5: If rounding carries out of the fraction, the significand becomes 1.0 and the exponent rises by one.
- R6: An operand whose exponent field is 0 is treated as zero whatever its fraction. Zero times a finite value gives a zero with fraction and exponent 0 and raises no flag.
- R7: Infinity (exponent 255, fraction 0) times a nonzero finite value, or times infinity, gives infinity and raises no flag.
- R8: Zero times infinity, or any NaN operand (exponent 255, nonzero fraction), gives 0x7FC00000 and sets flag_invalid.
- R9: If the rounded exponent exceeds 254, the result is infinity with the computed sign and flag_overflow is set.
- R10: If the rounded exponent is below 1, the result is zero with the computed sign and flag_underflow is set.
- R11: At most one of the three flags is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| trunc_mode | input | 1 | 1 truncates, 0 rounds to nearest-even |
| product | output | 32 | Registered packed product |
| flag_invalid | output | 1 | NaN produced from an invalid operation or a NaN input |
| flag_overflow | output | 1 | Result exponent too large, infinity returned |
| flag_underflow | output | 1 | Result exponent too small, zero returned |

## Verification
Several properties are checked on every cycle. At most one flag is raised at a time. Each flag comes with the output encoding it implies. Every non-NaN result carries the XOR of the previous cycle's operand signs, and a zero-exponent operand never yields a nonzero magnitude. Numeric correctness is left to the bench's directed scenarios: the normalizing shift, round-to-nearest ties to even against truncation, the carry-out renormalization and the exact range boundaries.

// File: rtl/fp_mul32.sv
module fp_mul32 #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EW+FW:0]     op_a,
  input  logic [EW+FW:0]     op_b,
  input  logic               trunc_mode,
  output logic [EW+FW:0]     product,
  output logic               flag_invalid,
  output logic               flag_overflow,
  output logic               flag_underflow
);
  localparam int W  = EW + FW + 1;
  localparam int SW = FW + 1;
  localparam int PW = 2 * SW;
  localparam int XW = EW + 2;
  localparam logic signed [XW-1:0] BIAS = XW'(2 ** (EW - 1) - 1);
  localparam logic signed [XW-1:0] EMAX = XW'(2 ** EW - 2);
  localparam logic [W-2:0] INF_MAG = {{EW{1'b1}}, {FW{1'b0}}};
  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  logic [EW-1:0] ea, eb;
  logic [FW-1:0] fa, fb;
  logic          sgn;
  assign ea  = op_a[W-2:FW];
  assign eb  = op_b[W-2:FW];
  assign fa  = op_a[FW-1:0];
  assign fb  = op_b[FW-1:0];
  assign sgn = op_a[W-1] ^ op_b[W-1];

  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign a_inf  = (ea == '1) && (fa == '0);
  assign b_inf  = (eb == '1) && (fb == '0);
  assign a_nan  = (ea == '1) && (fa != '0);
  assign b_nan  = (eb == '1) && (fb != '0);

  logic [PW-1:0] prod;
  assign prod = {1'b1, fa} * {1'b1, fb};

  logic          hi;
  logic [FW-1:0] mant;
  logic          guard, sticky, rup;
  assign hi     = prod[PW-1];
  assign mant   = hi ? prod[PW-2 -: FW] : prod[PW-3 -: FW];
  assign guard  = hi ? prod[FW] : prod[FW-1];
  assign sticky = hi ? |prod[FW-1:0] : |prod[FW-2:0];
  assign rup    = !trunc_mode && guard && (sticky || mant[0]);

  logic          cy;
  logic [FW-1:0] mr;
  assign {cy, mr} = {1'b0, mant} + {{FW{1'b0}}, rup};

  logic signed [XW-1:0] e_sum, e_fin;
  assign e_sum = $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS;
  assign e_fin = e_sum + $signed({{(XW-1){1'b0}}, hi}) + $signed({{(XW-1){1'b0}}, cy});

  logic [W-1:0] res_d;
  logic         inv_d, ovf_d, unf_d;

  always_comb begin
    res_d = {sgn, e_fin[EW-1:0], mr};
    inv_d = 1'b0;
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (a_nan || b_nan || (a_zero && b_inf) || (b_zero && a_inf)) begin
      res_d = QNAN;
      inv_d = 1'b1;
    end else if (a_inf || b_inf) begin
      res_d = {sgn, INF_MAG};
    end else if (a_zero || b_zero) begin
      res_d = {sgn, {(W-1){1'b0}}};
    end else if (e_fin > EMAX) begin
      res_d = {sgn, INF_MAG};
      ovf_d = 1'b1;
    end else if (e_fin < XW'(1)) begin
      res_d = {sgn, {(W-1){1'b0}}};
      unf_d = 1'b1;
    end
  end

  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product        <= '0;
      flag_invalid   <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_underflow <= 1'b0;
      seen           <= 1'b0;
    end else begin
      product        <= res_d;
      flag_invalid   <= inv_d;
      flag_overflow  <= ovf_d;
      flag_underflow <= unf_d;
      seen           <= 1'b1;
    end
  end

  p_one_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_invalid, flag_overflow, flag_underflow}));

  p_invalid_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> product == QNAN);

  p_overflow_inf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> product[W-2:0] == INF_MAG);

  p_underflow_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_underflow |-> product[W-2:0] == '0);

  p_sign_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !flag_invalid) |-> product[W-1] == $past(op_a[W-1] ^ op_b[W-1]));

  p_zero_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_a[W-2:FW] == '0 && op_b[W-2:FW] != '1)) |-> product[W-2:0] == '0);
endmodule

// File: tb/fp_mul32_test.sv
module fp_mul32_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        trunc_mode = 1'b0;
  logic [31:0] product;
  logic        flag_invalid, flag_overflow, flag_underflow;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_mul32 uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .trunc_mode(trunc_mode),
    .product(product), .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow)
  );

  task automatic expect_out(string req, logic [31:0] exp_p, logic [2:0] exp_f);
    n_run++;
    if (product !== exp_p || {flag_invalid, flag_overflow, flag_underflow} !== exp_f) begin
      n_fail++;
      $display("FAIL %s: got %h flags %b, expected %h flags %b", req, product,
               {flag_invalid, flag_overflow, flag_underflow}, exp_p, exp_f);
    end
  endtask

  task automatic mul(string req, logic [31:0] a, logic [31:0] b, logic tr,
                     logic [31:0] exp_p, logic [2:0] exp_f);
    @(negedge clk);
    op_a = a; op_b = b; trunc_mode = tr;
    @(posedge clk);
    @(negedge clk);
    expect_out(req, exp_p, exp_f);
  endtask

  task automatic t_reset;
    op_a = 32'h3FC00000; op_b = 32'h40000000;
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 32'h0, 3'b000);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expect_out("R1 latency", 32'h40400000, 3'b000);
  endtask

  task automatic t_normal;
    mul("R3 1.5x2", 32'h3FC00000, 32'h40000000, 1'b0, 32'h40400000, 3'b000);
    mul("R3 shift 1.5x1.5", 32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40100000, 3'b000);
    mul("R2 R3 -2x3", 32'hC0000000, 32'h40400000, 1'b0, 32'hC0C00000, 3'b000);
    mul("R3 low edge exp 1", 32'h00800000, 32'h3F800000, 1'b0, 32'h00800000, 3'b000);
    mul("R3 high edge exp 254", 32'h7F000000, 32'h3F800000, 1'b0, 32'h7F000000, 3'b000);
  endtask

  task automatic t_round;
    mul("R4 tie odd rounds up", 32'h3F800001, 32'h3FC00000, 1'b0, 32'h3FC00002, 3'b000);
    mul("R4 tie odd truncated", 32'h3F800001, 32'h3FC00000, 1'b1, 32'h3FC00001, 3'b000);
    mul("R4 tie even kept", 32'h3F800003, 32'h3FC00000, 1'b0, 32'h3FC00004, 3'b000);
    mul("R4 above half", 32'h3F800001, 32'h3FC00001, 1'b0, 32'h3FC00003, 3'b000);
    mul("R4 above half trunc", 32'h3F800001, 32'h3FC00001, 1'b1, 32'h3FC00002, 3'b000);
  endtask

  task automatic t_carry;
    mul("R5 carry renormalize", 32'h3FFFFFFE, 32'h3F800001, 1'b0, 32'h40000000, 3'b000);
    mul("R5 no carry on trunc", 32'h3FFFFFFE, 32'h3F800001, 1'b1, 32'h3FFFFFFF, 3'b000);
  endtask

  task automatic t_zero;
    mul("R6 +0x5", 32'h00000000, 32'h40A00000, 1'b0, 32'h00000000, 3'b000);
    mul("R6 R2 -0x5", 32'h80000000, 32'h40A00000, 1'b0, 32'h80000000, 3'b000);
    mul("R6 subnormal flushed", 32'h80000123, 32'h3F800000, 1'b0, 32'h80000000, 3'b000);
  endtask

  task automatic t_inf;
    mul("R7 inf x -2", 32'h7F800000, 32'hC0000000, 1'b0, 32'hFF800000, 3'b000);
    mul("R7 inf x inf", 32'hFF800000, 32'hFF800000, 1'b0, 32'h7F800000, 3'b000);
  endtask

  task automatic t_invalid;
    mul("R8 0 x inf", 32'h00000000, 32'hFF800000, 1'b0, 32'h7FC00000, 3'b100);
    mul("R8 nan x 1", 32'h7F800001, 32'h3F800000, 1'b0, 32'h7FC00000, 3'b100);
    mul("R8 1 x nan", 32'h3F800000, 32'hFFC00000, 1'b0, 32'h7FC00000, 3'b100);
  endtask

  task automatic t_range;
    mul("R9 overflow", 32'h7F000000, 32'h40000000, 1'b0, 32'h7F800000, 3'b010);
    mul("R9 R2 neg overflow", 32'hFF000000, 32'h40000000, 1'b0, 32'hFF800000, 3'b010);
    mul("R10 underflow", 32'h00800000, 32'h3F000000, 1'b0, 32'h00000000, 3'b001);
    mul("R10 R2 neg underflow", 32'h80800000, 32'h3F000000, 1'b0, 32'h80000000, 3'b001);
    mul("R11 flags clear after", 32'h3FC00000, 32'h40000000, 1'b0, 32'h40400000, 3'b000);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_round();
    t_carry();
    t_zero();
    t_inf();
    t_invalid();
    t_range();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule